// File: doc/BRIEF.md
# Twelve-bit sample packer and unpacker with output gain

This datapath sits between a sample stream and byte-wide storage. Audio samples carry 12 bits of resolution but travel in 16-bit words. The store direction accepts two such words and emits their 24 significant bits as three bytes. The fetch direction collects three bytes, rebuilds two 16-bit sample words, and applies a digital gain before presenting them. A mute input silences the fetched stream while it keeps flowing.

Samples are unsigned and centred on mid-scale 2048. Gain scales the distance from mid-scale, so a quiet signal stays centred. Both directions count samples and bytes inside blocks of a parameterised length (240 samples, 360 bytes by default) and flag the final item of each block. Both directions use valid/ready handshakes. A stalled consumer holds the path without dropping or reordering data.

Top module: `pcm12_packer_top`

## Requirements
- R1: After reset both output valids are low and both input readies are high.
- R2: A pair of samples A then B is emitted as three bytes in this order: A[11:4], then {A[3:0], B[11:8]}, then B[7:0].
- R3: The fetch direction rebuilds A and B from three bytes in the R2 layout. Each sample is output as {4'b0000, sample[11:0]}, and at gain 255 the 12-bit value is unchanged.
- R4: At a gain g below 255 and with mute low, the output equals floor((s - 2048) * g / 256) + 2048, where s is the 12-bit sample.
- R5: With mute high, every fetched sample is output as 16'h0800 and the stream keeps its count and order. When mute returns low, the next samples are scaled normally again.
- R6: The store direction raises its block-end flag together with the 360th byte of every 360-byte block, and with no other byte.
- R7: The fetch direction raises its block-end flag together with the 240th sample of every 240-sample block, and with no other sample.
- R8: While an output is valid and not accepted, its data and flag stay stable. Once it is accepted, no item is lost or reordered.
- R9: The store direction ignores bits 15:12 of each input word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pk_in_valid | input | 1 | Sample word offered to the store direction |
| pk_in_ready | output | 1 | Store direction accepts a sample word |
| pk_in_word | input | 16 | Sample word; bits 11:0 carry the sample |
| pk_out_valid | output | 1 | Packed byte available |
| pk_out_ready | input | 1 | Consumer takes the packed byte |
| pk_out_byte | output | 8 | Packed byte |
| pk_out_last | output | 1 | Final byte of a block |
| up_in_valid | input | 1 | Packed byte offered to the fetch direction |
| up_in_ready | output | 1 | Fetch direction accepts a byte |
| up_in_byte | input | 8 | Packed byte |
| up_out_valid | output | 1 | Rebuilt sample word available |
| up_out_ready | input | 1 | Consumer takes the sample word |
| up_out_word | output | 16 | Rebuilt, gain-scaled sample word |
| up_out_last | output | 1 | Final sample of a block |
| vol_gain | input | 8 | Gain factor; 255 means unity |
| mute | input | 1 | Force output to mid-scale |

## Verification
A wrong pair or byte phase in either direction shows as swapped nibbles in the very next output item. It keeps showing on every later item, so fixed patterns with distinct nibbles expose it within one pair. A block position counter that is off by one moves the end flag away from item 360 or item 240, which shows up only at the block boundary. For that reason whole blocks are streamed from reset. Gain arithmetic errors such as a rounding direction or a sign extension show only for samples below mid-scale at a non-unity gain, and that case is exercised directly.

// File: rtl/pcm12_pkg.sv
package pcm12_pkg;
    localparam int SMP_W   = 12;
    localparam int WORD_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int GAIN_W  = 8;
    localparam int PAIR_W  = 2 * SMP_W;
    localparam logic [SMP_W-1:0]  MID_SCALE  = 12'd2048;
    localparam logic [GAIN_W-1:0] GAIN_UNITY = 8'd255;
endpackage

// File: rtl/pcm12_packer.sv
module pcm12_packer
    import pcm12_pkg::*;
#(
    parameter int BLK_SAMPLES = 240
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_last
);
    localparam int BLK_BYTES = BLK_SAMPLES * 3 / 2;
    localparam int POS_W     = $clog2(BLK_BYTES);
    localparam logic [POS_W-1:0] POS_END = POS_W'(BLK_BYTES - 1);

    typedef struct packed {
        logic              have_a;
        logic [1:0]        left;
        logic [PAIR_W-1:0] sh;
        logic [POS_W-1:0]  pos;
    } pk_state_t;

    pk_state_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        in_ready  = (st_q.left == 2'd0);
        out_valid = (st_q.left != 2'd0);
        out_byte  = st_q.sh[PAIR_W-1 -: BYTE_W];
        out_last  = (st_q.pos == POS_END);
        if (in_valid && in_ready) begin
            if (!st_q.have_a) begin
                st_d.sh[PAIR_W-1 -: SMP_W] = in_word[SMP_W-1:0];
                st_d.have_a                = 1'b1;
            end else begin
                st_d.sh[SMP_W-1:0] = in_word[SMP_W-1:0];
                st_d.have_a        = 1'b0;
                st_d.left          = 2'd3;
            end
        end
        if (out_valid && out_ready) begin
            st_d.sh   = {st_q.sh[PAIR_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
            st_d.left = st_q.left - 2'd1;
            st_d.pos  = (st_q.pos == POS_END) ? '0 : st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_PK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_last)); // R8
    AST_PK_BYTES_AFTER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready)); // R2
endmodule

// File: rtl/pcm12_unpacker.sv
module pcm12_unpacker
    import pcm12_pkg::*;
#(
    parameter int BLK_SAMPLES = 240
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word,
    output logic              out_last,
    input  logic [GAIN_W-1:0] gain,
    input  logic              mute
);
    localparam int POS_W = $clog2(BLK_SAMPLES);
    localparam logic [POS_W-1:0] POS_END = POS_W'(BLK_SAMPLES - 1);

    typedef struct packed {
        logic [1:0]          got;
        logic [2*BYTE_W-1:0] hold;
        logic [SMP_W-1:0]    smp_a;
        logic [SMP_W-1:0]    smp_b;
        logic [1:0]          pend;
        logic [POS_W-1:0]    pos;
    } up_state_t;

    up_state_t st_q, st_d;

    logic [SMP_W-1:0]          raw;
    logic signed [SMP_W:0]     offs;
    logic signed [GAIN_W+1:0]  gs;
    logic signed [SMP_W+GAIN_W+2:0] prod;
    logic signed [SMP_W+GAIN_W+2:0] shifted;
    logic [SMP_W:0]            summed;
    logic [SMP_W-1:0]          scaled;

    always_comb begin
        raw     = (st_q.pend == 2'd2) ? st_q.smp_a : st_q.smp_b;
        offs    = $signed({1'b0, raw}) - $signed({1'b0, MID_SCALE});
        gs      = $signed({2'b00, gain});
        prod    = offs * gs;
        shifted = prod >>> GAIN_W;
        summed  = shifted[SMP_W:0] + {1'b0, MID_SCALE};
        if (mute)                    scaled = MID_SCALE;
        else if (gain == GAIN_UNITY) scaled = raw;
        else                         scaled = summed[SMP_W-1:0];
    end

    always_comb begin
        st_d      = st_q;
        in_ready  = (st_q.pend == 2'd0);
        out_valid = (st_q.pend != 2'd0);
        out_word  = {{(WORD_W-SMP_W){1'b0}}, scaled};
        out_last  = (st_q.pos == POS_END);
        if (in_valid && in_ready) begin
            case (st_q.got)
                2'd0: begin
                    st_d.hold[2*BYTE_W-1:BYTE_W] = in_byte;
                    st_d.got = 2'd1;
                end
                2'd1: begin
                    st_d.hold[BYTE_W-1:0] = in_byte;
                    st_d.got = 2'd2;
                end
                default: begin
                    st_d.smp_a = st_q.hold[2*BYTE_W-1:2*BYTE_W-SMP_W];
                    st_d.smp_b = {st_q.hold[2*BYTE_W-SMP_W-1:0], in_byte};
                    st_d.pend  = 2'd2;
                    st_d.got   = 2'd0;
                end
            endcase
        end
        if (out_valid && out_ready) begin
            st_d.pend = st_q.pend - 2'd1;
            st_d.pos  = (st_q.pos == POS_END) ? '0 : st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_UP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && $stable(gain) && $stable(mute)
        |=> out_valid && $stable(out_word) && $stable(out_last)); // R8
    AST_UP_SAMPLES_AFTER_TRIPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready)); // R3
    AST_UP_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_word[WORD_W-1:SMP_W] == '0); // R3
endmodule

// File: rtl/pcm12_packer_top.sv
module pcm12_packer_top
    import pcm12_pkg::*;
#(
    parameter int BLK_SAMPLES = 240
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pk_in_valid,
    output logic        pk_in_ready,
    input  logic [15:0] pk_in_word,
    output logic        pk_out_valid,
    input  logic        pk_out_ready,
    output logic [7:0]  pk_out_byte,
    output logic        pk_out_last,
    input  logic        up_in_valid,
    output logic        up_in_ready,
    input  logic [7:0]  up_in_byte,
    output logic        up_out_valid,
    input  logic        up_out_ready,
    output logic [15:0] up_out_word,
    output logic        up_out_last,
    input  logic [7:0]  vol_gain,
    input  logic        mute
);
    pcm12_packer #(.BLK_SAMPLES(BLK_SAMPLES)) u_pack (
        .clk(clk), .rst_n(rst_n),
        .in_valid(pk_in_valid), .in_ready(pk_in_ready), .in_word(pk_in_word),
        .out_valid(pk_out_valid), .out_ready(pk_out_ready),
        .out_byte(pk_out_byte), .out_last(pk_out_last)
    );

    pcm12_unpacker #(.BLK_SAMPLES(BLK_SAMPLES)) u_unpack (
        .clk(clk), .rst_n(rst_n),
        .in_valid(up_in_valid), .in_ready(up_in_ready), .in_byte(up_in_byte),
        .out_valid(up_out_valid), .out_ready(up_out_ready),
        .out_word(up_out_word), .out_last(up_out_last),
        .gain(vol_gain), .mute(mute)
    );
endmodule

// File: tb/pcm12_packer_top_bench.sv
module pcm12_packer_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pk_in_valid = 1'b0;
    logic        pk_in_ready;
    logic [15:0] pk_in_word = '0;
    logic        pk_out_valid;
    logic        pk_out_ready = 1'b0;
    logic [7:0]  pk_out_byte;
    logic        pk_out_last;
    logic        up_in_valid = 1'b0;
    logic        up_in_ready;
    logic [7:0]  up_in_byte = '0;
    logic        up_out_valid;
    logic        up_out_ready = 1'b0;
    logic [15:0] up_out_word;
    logic        up_out_last;
    logic [7:0]  vol_gain = 8'd255;
    logic        mute = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pcm12_packer_top u_pcm12_packer_top (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int exp_word(input int s, input int g, input bit m);
        int p;
        if (m) return 2048;
        if (g == 255) return s;
        p = (s - 2048) * g;
        return (p >>> 8) + 2048;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic push_s(input logic [15:0] w);
        @(negedge clk);
        pk_in_valid = 1'b1; pk_in_word = w;
        while (!pk_in_ready) @(negedge clk);
        @(posedge clk); #1;
        pk_in_valid = 1'b0;
    endtask

    task automatic pull_b(output logic [7:0] d, output logic l);
        @(negedge clk);
        pk_out_ready = 1'b1;
        while (!pk_out_valid) @(negedge clk);
        d = pk_out_byte; l = pk_out_last;
        @(posedge clk); #1;
        pk_out_ready = 1'b0;
    endtask

    task automatic push_b(input logic [7:0] b);
        @(negedge clk);
        up_in_valid = 1'b1; up_in_byte = b;
        while (!up_in_ready) @(negedge clk);
        @(posedge clk); #1;
        up_in_valid = 1'b0;
    endtask

    task automatic pull_s(output logic [15:0] w, output logic l);
        @(negedge clk);
        up_out_ready = 1'b1;
        while (!up_out_valid) @(negedge clk);
        w = up_out_word; l = up_out_last;
        @(posedge clk); #1;
        up_out_ready = 1'b0;
    endtask

    task automatic pack_pair(input string req, input logic [15:0] a, input logic [15:0] b);
        logic [7:0] d; logic l;
        logic [11:0] sa, sb;
        sa = a[11:0]; sb = b[11:0];
        push_s(a); push_s(b);
        pull_b(d, l); check(req, d, sa[11:4]);
        pull_b(d, l); check(req, d, {sa[3:0], sb[11:8]});
        pull_b(d, l); check(req, d, sb[7:0]);
    endtask

    task automatic unpack_pair(input string req, input logic [11:0] a, input logic [11:0] b);
        logic [15:0] w; logic l;
        push_b(a[11:4]); push_b({a[3:0], b[11:8]}); push_b(b[7:0]);
        pull_s(w, l); check(req, w, exp_word(a, vol_gain, mute));
        pull_s(w, l); check(req, w, exp_word(b, vol_gain, mute));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 out valids", {pk_out_valid, up_out_valid}, 0);
        check("R1 in readies", {pk_in_ready, up_in_ready}, 3);
    endtask

    task automatic t_pack_order();
        pack_pair("R2 order", 16'h0ABC, 16'h0123);
        pack_pair("R2 extremes", 16'h0FFF, 16'h0000);
        pack_pair("R9 upper bits ignored", 16'hF5A5, 16'hAE3C);
    endtask

    task automatic t_pack_stall();
        logic [7:0] d; logic l;
        push_s(16'h0321); push_s(16'h0654);
        repeat (2) @(negedge clk);
        d = pk_out_byte;
        repeat (5) @(negedge clk);
        check("R8 pack stall valid", pk_out_valid, 1);
        check("R8 pack stall data", pk_out_byte, d);
        pull_b(d, l); check("R8 pack b0", d, 8'h32);
        pull_b(d, l); check("R8 pack b1", d, 8'h16);
        pull_b(d, l); check("R8 pack b2", d, 8'h54);
    endtask

    task automatic t_unpack();
        vol_gain = 8'd255; mute = 1'b0;
        unpack_pair("R3 unity", 12'hABC, 12'h123);
        unpack_pair("R3 extremes", 12'hFFF, 12'h000);
        vol_gain = 8'd128;
        unpack_pair("R4 half gain", 12'hC00, 12'h000);
        vol_gain = 8'd0;
        unpack_pair("R4 zero gain", 12'hFFF, 12'h123);
        vol_gain = 8'd64;
        unpack_pair("R4 floor negative", 12'h7FF, 12'h801);
        vol_gain = 8'd200;
        mute = 1'b1;
        unpack_pair("R5 muted", 12'hFFF, 12'h001);
        mute = 1'b0;
        unpack_pair("R5 unmuted", 12'hE00, 12'h100);
        vol_gain = 8'd255;
    endtask

    task automatic t_unpack_stall();
        logic [15:0] w, w0; logic l;
        push_b(8'h9A); push_b(8'hB5); push_b(8'h67);
        repeat (2) @(negedge clk);
        w0 = up_out_word;
        repeat (5) @(negedge clk);
        check("R8 unpack stall valid", up_out_valid, 1);
        check("R8 unpack stall data", up_out_word, w0);
        pull_s(w, l); check("R8 unpack s0", w, 16'h09AB);
        pull_s(w, l); check("R8 unpack s1", w, 16'h0567);
    endtask

    task automatic t_pack_block();
        logic [7:0] d; logic l;
        int n_last = 0, where = -1;
        do_reset();
        for (int p = 0; p < 120; p++) begin
            push_s(16'(p * 7)); push_s(16'(p * 13 + 5));
            for (int k = 0; k < 3; k++) begin
                pull_b(d, l);
                if (l) begin n_last++; where = p * 3 + k; end
            end
        end
        check("R6 block flag count", n_last, 1);
        check("R6 block flag position", where, 359);
        push_s(16'h0111); push_s(16'h0222);
        pull_b(d, l); check("R6 next block first byte", l, 0);
        pull_b(d, l); pull_b(d, l);
    endtask

    task automatic t_unpack_block();
        logic [15:0] w; logic l;
        int n_last = 0, where = -1;
        do_reset();
        vol_gain = 8'd255; mute = 1'b0;
        for (int p = 0; p < 120; p++) begin
            push_b(8'(p)); push_b(8'h5A); push_b(8'(p + 3));
            for (int k = 0; k < 2; k++) begin
                pull_s(w, l);
                if (l) begin n_last++; where = p * 2 + k; end
            end
        end
        check("R7 block flag count", n_last, 1);
        check("R7 block flag position", where, 239);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_pack_order();
        t_pack_stall();
        t_unpack();
        t_unpack_stall();
        t_pack_block();
        t_unpack_block();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1500000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule